// File: doc/BRIEF.md
# Serial Bus Status and Byte Buffering Core

This block sits between a processor and the symbol encoder/decoder of a vehicle serial bus controller. It holds received bytes in a two-slot queue (a front register the processor reads, backed by one spare slot). Bytes to send go through a matching two-slot queue (a front register the transmitter takes from, backed by one spare slot). It also keeps one 8-bit status byte. That byte gathers sticky event flags, a processor-written enable bit and a live bus-busy indication.

The flags are set by one-cycle strobes from the encoder and decoder. The events are: an in-frame response byte accepted, arbitration lost, a break symbol seen, a message sent and a message received. Both queue faults share one flag: a received byte that finds both receive slots full, and a transmitter request that finds the transmit queue empty. Reading the status returns the current byte and clears every stored bit, the enable bit included. The processor therefore writes the status again before each message it sends.

Top module: `sbus_status_core`

## Requirements
- R1: After a synchronous reset, the status byte reads 0x00 (with `bus_busy` low), `rx_avail` is 0, `tx_byte_vld` is 0 and `tx_full` is 0.
- R2: The status bit positions are 7 IFR byte accepted, 6 arbitration lost, 5 bus busy, 4 break seen, 3 overrun/underflow, 2 message sent, 1 message received, 0 enable. A one-cycle pulse on `arb_lost`, `brk_seen`, `msg_tx_done` or `msg_rx_done` sets bit 6, 4, 2 or 1 respectively, and the bit stays set.
- R3: A cycle with `stat_rd` high clears every stored status bit, bit 0 included. `stat_rdata` during that cycle shows the value from before the clear.
- R4: Bit 5 always equals the current `bus_busy` input and is not affected by a read.
- R5: An event strobe in the same cycle as a read-clear leaves its flag set.
- R6: A `stat_wr` cycle loads bits 7, 6 and 4..0 from `stat_wdata`; bit 5 of the written data is ignored. `tx_en` follows bit 0.
- R7: Received bytes reach `rx_data` in arrival order. `rx_avail` is high while the front register holds a byte. A pulse on `rx_rd` moves the spare slot forward.
- R8: A byte pushed while both receive slots are full and no `rx_rd` is present sets bit 3. That byte is discarded, and the two stored bytes are kept in order.
- R9: `tx_wr` fills the front transmit register first and the spare slot second. `tx_pop` takes the front byte, and the spare slot refills the front. `tx_full` is high when both slots are occupied.
- R10: A `tx_pop` while no transmit byte is stored sets bit 3. A `tx_wr` while `tx_full` is high, with no pop in the same cycle, is ignored.
- R11: A byte accepted into the receive queue with `rx_push_ifr` high sets bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Live bus activity level |
| rx_push | input | 1 | Decoder delivers a received byte |
| rx_push_data | input | DATA_W | Received byte |
| rx_push_ifr | input | 1 | Received byte is an in-frame response |
| arb_lost | input | 1 | Arbitration lost strobe |
| brk_seen | input | 1 | Break symbol detected strobe |
| msg_tx_done | input | 1 | Message sent strobe |
| msg_rx_done | input | 1 | Message received strobe |
| tx_pop | input | 1 | Encoder takes the front transmit byte |
| tx_byte | output | DATA_W | Front transmit byte |
| tx_byte_vld | output | 1 | Front transmit byte present |
| stat_rd | input | 1 | Processor status read (clears) |
| stat_wr | input | 1 | Processor status write |
| stat_wdata | input | 8 | Status write data |
| stat_rdata | output | 8 | Status byte |
| tx_en | output | 1 | Enable bit of the status byte |
| rx_rd | input | 1 | Processor takes the front received byte |
| rx_data | output | DATA_W | Front received byte |
| rx_avail | output | 1 | Front received byte present |
| tx_wr | input | 1 | Processor writes a byte to send |
| tx_wdata | input | DATA_W | Byte to send |
| tx_full | output | 1 | Both transmit slots occupied |

## Verification
The assertions assume that every event input is a pulse lasting one clock, and that `bus_busy` is a plain level sampled on the same clock. The post-clear check on the status register also assumes that no status write coincides with the read. The bench drives each strobe for exactly one cycle from the falling edge and drops it on the next falling edge. It never raises the status read and write together, and it spaces queue pushes and reads one per cycle, so the one-cycle forwarding from spare slot to front register is always settled when the outputs are sampled.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int BYTE_W = 8;

    // Status byte layout, MSB first; the processor decodes these positions.
    typedef struct packed {
        logic ifr;
        logic cont;
        logic busy;
        logic brk;
        logic ovun;
        logic mtx;
        logic mrx;
        logic en;
    } stat_t;

    // Set requests gathered from the queues and the symbol logic.
    typedef struct packed {
        logic ifr;
        logic cont;
        logic brk;
        logic ovun;
        logic mtx;
        logic mrx;
    } evt_t;

    function automatic stat_t merge_evt(stat_t s, evt_t e);
        stat_t o;
        o      = s;
        o.ifr  = s.ifr  | e.ifr;
        o.cont = s.cont | e.cont;
        o.brk  = s.brk  | e.brk;
        o.ovun = s.ovun | e.ovun;
        o.mtx  = s.mtx  | e.mtx;
        o.mrx  = s.mrx  | e.mrx;
        return o;
    endfunction

endpackage

// File: rtl/sbus_rxq.sv
module sbus_rxq #(
    parameter int DW = sbus_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_d,
    input  logic          push_ifr,
    input  logic          pop,
    output logic          out_v,
    output logic [DW-1:0] out_d,
    output logic          ifr_acc,
    output logic          overrun
);
    logic          hold_v, spare_v, hold_v_n, spare_v_n, acc;
    logic [DW-1:0] hold_d, spare_d, hold_d_n, spare_d_n;

    always_comb begin
        hold_v_n  = hold_v;
        hold_d_n  = hold_d;
        spare_v_n = spare_v;
        spare_d_n = spare_d;
        acc       = 1'b0;
        overrun   = 1'b0;
        if (pop && hold_v) hold_v_n = 1'b0;
        if (!hold_v_n && spare_v_n) begin
            hold_v_n  = 1'b1;
            hold_d_n  = spare_d;
            spare_v_n = 1'b0;
        end
        if (push) begin
            if (!spare_v_n) begin
                spare_v_n = 1'b1;
                spare_d_n = push_d;
                acc       = 1'b1;
            end else begin
                overrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v  <= 1'b0;
            spare_v <= 1'b0;
            hold_d  <= '0;
            spare_d <= '0;
        end else begin
            hold_v  <= hold_v_n;
            spare_v <= spare_v_n;
            hold_d  <= hold_d_n;
            spare_d <= spare_d_n;
        end
    end

    assign out_v   = hold_v;
    assign out_d   = hold_d;
    assign ifr_acc = acc && push_ifr;

    AST_RX_KEEP_STORED: assert property (@(posedge clk) disable iff (rst)
        (push && hold_v && spare_v && !pop) |=>
            (hold_v && spare_v && hold_d == $past(hold_d) && spare_d == $past(spare_d))) else $error("rx keep"); // R8

    AST_RX_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (!hold_v && spare_v) |=> (hold_v && hold_d == $past(spare_d))) else $error("rx forward"); // R7

endmodule

// File: rtl/sbus_txq.sv
module sbus_txq #(
    parameter int DW = sbus_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic          out_v,
    output logic [DW-1:0] out_d,
    output logic          full,
    output logic          underflow
);
    logic          hold_v, spare_v, hold_v_n, spare_v_n;
    logic [DW-1:0] hold_d, spare_d, hold_d_n, spare_d_n;

    always_comb begin
        hold_v_n  = hold_v;
        hold_d_n  = hold_d;
        spare_v_n = spare_v;
        spare_d_n = spare_d;
        if (pop && hold_v) begin
            hold_v_n  = spare_v;
            hold_d_n  = spare_d;
            spare_v_n = 1'b0;
        end
        if (wr) begin
            if (!hold_v_n) begin
                hold_v_n = 1'b1;
                hold_d_n = wdata;
            end else if (!spare_v_n) begin
                spare_v_n = 1'b1;
                spare_d_n = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v  <= 1'b0;
            spare_v <= 1'b0;
            hold_d  <= '0;
            spare_d <= '0;
        end else begin
            hold_v  <= hold_v_n;
            spare_v <= spare_v_n;
            hold_d  <= hold_d_n;
            spare_d <= spare_d_n;
        end
    end

    assign out_v     = hold_v;
    assign out_d     = hold_d;
    assign full      = hold_v && spare_v;
    assign underflow = pop && !hold_v;

    AST_TX_FRONT_FIRST: assert property (@(posedge clk) disable iff (rst)
        !hold_v |-> !spare_v) else $error("tx order"); // R9

    AST_TX_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr && hold_v && spare_v && !pop) |=>
            (hold_d == $past(hold_d) && spare_d == $past(spare_d))) else $error("tx drop"); // R10

endmodule

// File: rtl/sbus_stat.sv
module sbus_stat
    import sbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  evt_t       evt,
    input  logic       busy,
    output stat_t      cur
);
    stat_t r, base, nxt;

    always_comb begin
        base = r;
        if (rd) base = '0;
        if (wr) base = stat_t'(wdata);
        base.busy = 1'b0;
        nxt = merge_evt(base, evt);
    end

    always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= nxt;
    end

    always_comb begin
        cur      = r;
        cur.busy = busy;
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && evt.brk) |=> cur.brk) else $error("set wins"); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && evt == '0) |=> ({cur.ifr, cur.cont, cur.brk, cur.ovun, cur.mtx, cur.mrx, cur.en} == 7'd0)) else $error("read clear"); // R3

    AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (rst)
        evt.ovun |=> cur.ovun) else $error("ovun flag"); // R8

    AST_CONT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (cur.cont && !rd && !wr) |=> cur.cont) else $error("cont sticky"); // R2

endmodule

// File: rtl/sbus_status_core.sv
module sbus_status_core #(
    parameter int DATA_W = sbus_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_push_ifr,
    input  logic              arb_lost,
    input  logic              brk_seen,
    input  logic              msg_tx_done,
    input  logic              msg_rx_done,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_byte_vld,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    output logic [7:0]        stat_rdata,
    output logic              tx_en,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_avail,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full
);
    import sbus_pkg::*;

    logic  rx_ovr, rx_ifr, tx_udf;
    evt_t  evt;
    stat_t cur;

    sbus_rxq #(.DW(DATA_W)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_d(rx_push_data), .push_ifr(rx_push_ifr),
        .pop(rx_rd), .out_v(rx_avail), .out_d(rx_data),
        .ifr_acc(rx_ifr), .overrun(rx_ovr)
    );

    sbus_txq #(.DW(DATA_W)) u_txq (
        .clk(clk), .rst(rst),
        .wr(tx_wr), .wdata(tx_wdata), .pop(tx_pop),
        .out_v(tx_byte_vld), .out_d(tx_byte),
        .full(tx_full), .underflow(tx_udf)
    );

    always_comb begin
        evt.ifr  = rx_ifr;
        evt.cont = arb_lost;
        evt.brk  = brk_seen;
        evt.ovun = rx_ovr | tx_udf;
        evt.mtx  = msg_tx_done;
        evt.mrx  = msg_rx_done;
    end

    sbus_stat u_stat (
        .clk(clk), .rst(rst),
        .rd(stat_rd), .wr(stat_wr), .wdata(stat_wdata),
        .evt(evt), .busy(bus_busy), .cur(cur)
    );

    assign stat_rdata = cur;
    assign tx_en      = cur.en;

    AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && !tx_byte_vld) |=> stat_rdata[3]) else $error("underflow"); // R10

endmodule

// File: tb/sbus_status_core_test.sv
module sbus_status_core_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_busy, rx_push, rx_push_ifr, arb_lost, brk_seen;
    logic          msg_tx_done, msg_rx_done, tx_pop, stat_rd, stat_wr, rx_rd, tx_wr;
    logic [DW-1:0] rx_push_data, tx_wdata, tx_byte, rx_data;
    logic [7:0]    stat_wdata, stat_rdata;
    logic          tx_byte_vld, tx_en, rx_avail, tx_full;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sbus_status_core #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .bus_busy(bus_busy),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_ifr(rx_push_ifr),
        .arb_lost(arb_lost), .brk_seen(brk_seen),
        .msg_tx_done(msg_tx_done), .msg_rx_done(msg_rx_done),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_byte_vld(tx_byte_vld),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .tx_en(tx_en),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_stat(output logic [7:0] v);
        @(negedge clk);
        stat_rd = 1'b1;
        v = stat_rdata;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: arb_lost    = 1'b1;
            1: brk_seen    = 1'b1;
            2: msg_tx_done = 1'b1;
            default: msg_rx_done = 1'b1;
        endcase
        @(negedge clk);
        arb_lost = 1'b0; brk_seen = 1'b0; msg_tx_done = 1'b0; msg_rx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] evt_bit [4];
        evt_bit[0] = 8'h40; evt_bit[1] = 8'h10; evt_bit[2] = 8'h04; evt_bit[3] = 8'h02;

        rst = 1'b1; bus_busy = 0; rx_push = 0; rx_push_data = '0; rx_push_ifr = 0;
        arb_lost = 0; brk_seen = 0; msg_tx_done = 0; msg_rx_done = 0; tx_pop = 0;
        stat_rd = 0; stat_wr = 0; stat_wdata = '0; rx_rd = 0; tx_wr = 0; tx_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 status", stat_rdata, 8'h00);
        check("R1 rx_avail", rx_avail, 0);
        check("R1 tx_byte_vld", tx_byte_vld, 0);
        check("R1 tx_full", tx_full, 0);

        // R2 / R3 each event sets its own bit; read returns it and clears
        for (int k = 0; k < 4; k++) begin
            pulse_evt(k);
            check("R2 bit set", stat_rdata, evt_bit[k]);
            rd_stat(v);
            check("R3 read value", v, evt_bit[k]);
            check("R3 cleared", stat_rdata, 8'h00);
        end

        // R4 busy bit is live and survives a read
        @(negedge clk); bus_busy = 1'b1;
        #1 check("R4 busy high", stat_rdata, 8'h20);
        rd_stat(v);
        check("R4 busy after read", stat_rdata, 8'h20);
        bus_busy = 1'b0;
        #1 check("R4 busy low", stat_rdata, 8'h00);

        // R5 set and read-clear in the same cycle
        @(negedge clk); stat_rd = 1'b1; brk_seen = 1'b1;
        @(negedge clk); stat_rd = 1'b0; brk_seen = 1'b0;
        check("R5 set wins", stat_rdata, 8'h10);
        rd_stat(v);
        check("R5 then cleared", stat_rdata, 8'h00);

        // R6 write loads all but bit 5
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'hFF;
        @(negedge clk); stat_wr = 1'b0;
        check("R6 written", stat_rdata, 8'hDF);
        check("R6 tx_en", tx_en, 1);
        rd_stat(v);
        check("R6 tx_en cleared by read", tx_en, 0);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'h01;
        @(negedge clk); stat_wr = 1'b0;
        check("R6 enable only", stat_rdata, 8'h01);
        rd_stat(v);

        // R7 / R8 receive sweep: 1, 2 and 3 bytes back to back
        for (int n = 1; n <= 3; n++) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); rx_push = 1'b1; rx_push_data = 8'(16 * n + i);
            end
            @(negedge clk); rx_push = 1'b0;
            repeat (2) @(negedge clk);
            rd_stat(v);
            check("R8 overrun flag", v, (n == 3) ? 8'h08 : 8'h00);
            for (int i = 0; i < ((n > 2) ? 2 : n); i++) begin
                check("R7 rx_avail", rx_avail, 1);
                check("R7 rx order", rx_data, 8'(16 * n + i));
                rx_rd = 1'b1;
                @(negedge clk); rx_rd = 1'b0;
                @(negedge clk);
            end
            check("R8 rx drained", rx_avail, 0);
        end

        // R11 in-frame response byte
        @(negedge clk); rx_push = 1'b1; rx_push_ifr = 1'b1; rx_push_data = 8'h5A;
        @(negedge clk); rx_push = 1'b0; rx_push_ifr = 1'b0;
        @(negedge clk);
        rd_stat(v);
        check("R11 ifr flag", v, 8'h80);
        check("R11 ifr byte", rx_data, 8'h5A);
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;

        // R9 / R10 transmit sweep: 0..3 writes, drain, then one extra pop
        for (int n = 0; n <= 3; n++) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'(32 * n + i + 1);
            end
            @(negedge clk); tx_wr = 1'b0;
            check("R9 tx_full", tx_full, (n >= 2) ? 1 : 0);
            check("R9 tx_byte_vld", tx_byte_vld, (n >= 1) ? 1 : 0);
            for (int i = 0; i < ((n > 2) ? 2 : n); i++) begin
                check("R10 tx order / drop", tx_byte, 8'(32 * n + i + 1));
                tx_pop = 1'b1;
                @(negedge clk); tx_pop = 1'b0;
            end
            check("R10 tx empty", tx_byte_vld, 0);
            rd_stat(v);
            check("R10 no early underflow", v, 8'h00);
            @(negedge clk); tx_pop = 1'b1;
            @(negedge clk); tx_pop = 1'b0;
            rd_stat(v);
            check("R10 underflow flag", v, 8'h08);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule